// File: doc/BRIEF.md
# Three-Wire Control Port Receiver

This block is the receiving side of a write-only serial control bus driven by a host microcontroller. The bus has three wires: a bit clock, a phase line and a data line. The host first sends an address byte with the phase line low. That byte names the target device and the kind of transfer that follows. The host then raises the phase line and sends any number of data bytes. Each data byte carries its own two-bit register selector in its top bits.

The receiver brings the three wires into the system clock domain through synchronisers and finds the rising bit-clock edges there. It assembles bytes, least significant bit first, and updates a configuration bank. The bank holds the oversampling clock ratio, the audio input format, a volume attenuation code, the de-emphasis choice and a mute flag. The register values are driven continuously as outputs. A one-cycle strobe marks every accepted write.

Top module: `ctl3w_slave`

## Requirements
- R1: After reset, the outputs are clock ratio 2'b10 (256 times the sample rate), format 3'b000 (I2S), volume 6'd0 (0 dB), de-emphasis 2'b00 (off) and mute 0, and the update strobe is low.
- R2: Each byte is eight bits, sampled on rising bit-clock edges with bit 0 first and bit 7 last. No register changes until the eighth bit of a byte has been received.
- R3: A byte received while the phase line is low is an address byte. Its bits 7:2 must equal 6'b000101 to select the device. Any other value deselects it, and data bytes are then ignored until the next address byte.
- R4: Address bits 1:0 choose the transfer kind: 2'b00 selects the data bank and 2'b10 selects the status bank. With 2'b01 or 2'b11, data bytes are ignored.
- R5: A selection stays in force for any number of data bytes (phase line high) until the next address byte.
- R6: A status byte is accepted only when bits 7:6 are 2'b00. Bits 5:4 give the clock ratio (00 = 512x, 01 = 384x, 10 = 256x). Code 11 leaves the ratio unchanged.
- R7: In an accepted status byte, bits 3:1 give the format (000 I2S, 001/010/011 right-justified 16/18/20 bit, 100 left-justified). Codes 101 to 111 leave the format unchanged. Bit 0 is ignored.
- R8: A data-bank byte with bits 7:6 = 2'b00 loads bits 5:0 into the volume code.
- R9: A data-bank byte with bits 7:6 = 2'b10 loads bits 2:1 into de-emphasis (00 off, 01 32 kHz, 10 44.1 kHz, 11 48 kHz) and bit 0 into mute. Bytes with bits 7:6 = 01 or 11 are ignored.
- R10: The update strobe is high for exactly one cycle for each accepted status or data byte. It stays low for address bytes and ignored bytes, and the outputs change only in a strobe cycle.
- R11: Any change of the phase line discards the bits of an unfinished byte and restarts the bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial bit clock, asynchronous |
| ser_phase_i | input | 1 | Phase line: low for address, high for data |
| ser_dat_i | input | 1 | Serial data line |
| clk_ratio_o | output | 2 | Clock ratio code |
| fmt_o | output | 3 | Input format code |
| vol_o | output | 6 | Volume attenuation code |
| deemph_o | output | 2 | De-emphasis code |
| mute_o | output | 1 | Mute flag |
| upd_o | output | 1 | One-cycle strobe for each accepted write |

## Verification
The bench sends wrong device addresses and the two unused transfer kinds, then follows each with data bytes. A receiver that kept its old selection, or decoded only part of the address, would write registers it should leave alone. Status bytes carry an unused clock code next to a valid format code, and the reverse. A design that rejected the whole byte, or stored the illegal code, would show the wrong field. Other cases are a byte cut short by a phase change and a byte stopped after seven bits. A bit counter that did not restart, or wrote early, would misalign the next byte or pulse the strobe. Random traffic with repeated data bytes checks that a selection persists and that the bit order is least significant bit first.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 6;
    localparam logic [ADDR_W-1:0] DEF_DEV_ADDR = 6'b000101;

    typedef enum logic [1:0] {
        XFER_DATA = 2'b00,
        XFER_RSV1 = 2'b01,
        XFER_STAT = 2'b10,
        XFER_RSV3 = 2'b11
    } xfer_e;

    typedef struct packed {
        logic [1:0] ratio;
        logic [2:0] fmt;
        logic [5:0] vol;
        logic [1:0] deemph;
        logic       mute;
    } cfg_t;

    localparam cfg_t CFG_RST = '{ratio: 2'b10, fmt: 3'b000, vol: 6'd0,
                                 deemph: 2'b00, mute: 1'b0};
    localparam logic [2:0] FMT_MAX   = 3'd4;
    localparam logic [1:0] RATIO_BAD = 2'b11;
endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/ctl3w_shifter.sv
module ctl3w_shifter
    import ctl3w_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              sphase,
    input  logic              sdat,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_val,
    output logic              byte_is_addr
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        logic              sclk_prev;
        logic              phase_prev;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic              vld;
        logic [BYTE_W-1:0] data;
        logic              is_addr;
    } sh_t;

    sh_t s_d, s_q;

    always_comb begin
        s_d            = s_q;
        s_d.vld        = 1'b0;
        s_d.sclk_prev  = sclk;
        s_d.phase_prev = sphase;
        if (sphase != s_q.phase_prev) begin
            s_d.cnt = '0;
        end else if (sclk && !s_q.sclk_prev) begin
            s_d.sh = {sdat, s_q.sh[BYTE_W-1:1]};
            if (s_q.cnt == CNT_LAST) begin
                s_d.cnt     = '0;
                s_d.vld     = 1'b1;
                s_d.data    = {sdat, s_q.sh[BYTE_W-1:1]};
                s_d.is_addr = !sphase;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign byte_vld     = s_q.vld;
    assign byte_val     = s_q.data;
    assign byte_is_addr = s_q.is_addr;
endmodule

// File: rtl/ctl3w_regbank.sv
module ctl3w_regbank
    import ctl3w_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR = DEF_DEV_ADDR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_val,
    input  logic              byte_is_addr,
    output cfg_t              cfg,
    output logic              upd,
    output logic              sel_on
);
    typedef struct packed {
        logic  sel_on;
        xfer_e kind;
        cfg_t  cfg;
        logic  upd;
    } rb_t;

    rb_t r_d, r_q;
    logic [1:0] top2;

    assign top2 = byte_val[BYTE_W-1 -: 2];

    always_comb begin
        r_d     = r_q;
        r_d.upd = 1'b0;
        if (byte_vld) begin
            if (byte_is_addr) begin
                r_d.sel_on = (byte_val[BYTE_W-1 -: ADDR_W] == DEV_ADDR);
                r_d.kind   = xfer_e'(byte_val[1:0]);
            end else if (r_q.sel_on) begin
                case (r_q.kind)
                    XFER_STAT: begin
                        if (top2 == 2'b00) begin
                            r_d.upd = 1'b1;
                            if (byte_val[5:4] != RATIO_BAD) r_d.cfg.ratio = byte_val[5:4];
                            if (byte_val[3:1] <= FMT_MAX)   r_d.cfg.fmt   = byte_val[3:1];
                        end
                    end
                    XFER_DATA: begin
                        if (top2 == 2'b00) begin
                            r_d.upd     = 1'b1;
                            r_d.cfg.vol = byte_val[5:0];
                        end else if (top2 == 2'b10) begin
                            r_d.upd        = 1'b1;
                            r_d.cfg.deemph = byte_val[2:1];
                            r_d.cfg.mute   = byte_val[0];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{sel_on: 1'b0, kind: XFER_DATA, cfg: CFG_RST, upd: 1'b0};
        else        r_q <= r_d;
    end

    assign cfg    = r_q.cfg;
    assign upd    = r_q.upd;
    assign sel_on = r_q.sel_on;
endmodule

// File: rtl/ctl3w_slave.sv
module ctl3w_slave
    import ctl3w_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR    = DEF_DEV_ADDR,
    parameter int                SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ser_clk_i,
    input  logic       ser_phase_i,
    input  logic       ser_dat_i,
    output logic [1:0] clk_ratio_o,
    output logic [2:0] fmt_o,
    output logic [5:0] vol_o,
    output logic [1:0] deemph_o,
    output logic       mute_o,
    output logic       upd_o
);
    logic [2:0]        pins_s;
    logic              w_byte_vld;
    logic [BYTE_W-1:0] w_byte_val;
    logic              w_byte_is_addr;
    logic              w_sel_on;
    cfg_t              w_cfg;

    ctl3w_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ser_clk_i, ser_phase_i, ser_dat_i}),
        .dout (pins_s)
    );

    ctl3w_shifter u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk        (pins_s[2]),
        .sphase      (pins_s[1]),
        .sdat        (pins_s[0]),
        .byte_vld    (w_byte_vld),
        .byte_val    (w_byte_val),
        .byte_is_addr(w_byte_is_addr)
    );

    ctl3w_regbank #(.DEV_ADDR(DEV_ADDR)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_vld    (w_byte_vld),
        .byte_val    (w_byte_val),
        .byte_is_addr(w_byte_is_addr),
        .cfg         (w_cfg),
        .upd         (upd_o),
        .sel_on      (w_sel_on)
    );

    assign clk_ratio_o = w_cfg.ratio;
    assign fmt_o       = w_cfg.fmt;
    assign vol_o       = w_cfg.vol;
    assign deemph_o    = w_cfg.deemph;
    assign mute_o      = w_cfg.mute;
endmodule

// File: rtl/ctl3w_checker.sv
module ctl3w_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] ratio,
    input logic [2:0] fmt,
    input logic [5:0] vol,
    input logic [1:0] deemph,
    input logic       mute,
    input logic       upd,
    input logic       byte_vld,
    input logic       sel_on
);
    // R10
    upd_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd |-> $past(byte_vld));

    // R10
    upd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> !upd);

    // R10
    cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({ratio, fmt, vol, deemph, mute}) |-> upd);

    // R3
    upd_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd |-> $past(sel_on));

    // R6
    ratio_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ratio != 2'b11);

    // R7
    fmt_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fmt <= 3'd4);
endmodule

bind ctl3w_slave ctl3w_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ratio   (clk_ratio_o),
    .fmt     (fmt_o),
    .vol     (vol_o),
    .deemph  (deemph_o),
    .mute    (mute_o),
    .upd     (upd_o),
    .byte_vld(w_byte_vld),
    .sel_on  (w_sel_on)
);

// File: tb/sim_ctl3w_slave.sv
module sim_ctl3w_slave;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0, sphase = 1'b0, sdat = 1'b0;
    logic [1:0] clk_ratio_o, deemph_o;
    logic [2:0] fmt_o;
    logic [5:0] vol_o;
    logic       mute_o, upd_o;

    int n_tests = 0, n_fail = 0;
    int upd_cnt = 0, dbl_cnt = 0;
    logic upd_prev = 1'b0;

    logic [1:0] e_ratio = 2'b10, e_de = 2'b00, e_kind = 2'b00;
    logic [2:0] e_fmt = 3'b000;
    logic [5:0] e_vol = 6'd0;
    logic       e_mute = 1'b0, e_sel = 1'b0;
    int         e_upd = 0;

    always #10 clk = ~clk;

    ctl3w_slave u0 (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_phase_i(sphase),
        .ser_dat_i(sdat), .clk_ratio_o(clk_ratio_o), .fmt_o(fmt_o),
        .vol_o(vol_o), .deemph_o(deemph_o), .mute_o(mute_o), .upd_o(upd_o)
    );

    always @(negedge clk) begin
        if (upd_o) upd_cnt++;
        if (upd_o && upd_prev) dbl_cnt++;
        upd_prev = upd_o;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        @(negedge clk);
        chk(req, "ratio", clk_ratio_o, e_ratio);
        chk(req, "fmt", fmt_o, e_fmt);
        chk(req, "vol", vol_o, e_vol);
        chk(req, "deemph", deemph_o, e_de);
        chk(req, "mute", mute_o, e_mute);
        chk(req, "upd count R10", upd_cnt, e_upd);
        chk(req, "double strobe R10", dbl_cnt, 0);
    endtask

    // expected-value model, built from the requirements
    task automatic model(input logic is_addr, input logic [7:0] b);
        if (is_addr) begin
            e_sel  = (b[7:2] == 6'b000101);
            e_kind = b[1:0];
        end else if (e_sel) begin
            if (e_kind == 2'b10 && b[7:6] == 2'b00) begin
                e_upd++;
                if (b[5:4] != 2'b11) e_ratio = b[5:4];
                if (b[3:1] <= 3'd4)  e_fmt   = b[3:1];
            end else if (e_kind == 2'b00 && b[7:6] == 2'b00) begin
                e_upd++;
                e_vol = b[5:0];
            end else if (e_kind == 2'b00 && b[7:6] == 2'b10) begin
                e_upd++;
                e_de   = b[2:1];
                e_mute = b[0];
            end
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_phase(input logic p);
        @(negedge clk) sphase = p;
        wait_clk(4);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk) sdat = b[i];
            wait_clk(3);
            sclk = 1'b1;
            wait_clk(3);
            sclk = 1'b0;
        end
    endtask

    task automatic send_byte(input logic is_addr, input logic [7:0] b);
        if (sphase != !is_addr) set_phase(!is_addr);
        send_bits(b, 8);
        wait_clk(8);
        model(is_addr, b);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h00c0_ffee));
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        check_all("R1");

        // R3 R8: matching address, data kind, volume byte
        send_byte(1'b1, 8'b0001_0100);
        check_all("R3");
        send_byte(1'b0, 8'b0001_0101);
        check_all("R8");
        // R5: further data bytes without a new address
        send_byte(1'b0, 8'b0000_0011);
        check_all("R5");
        send_byte(1'b0, 8'b1000_0101);
        check_all("R9");
        send_byte(1'b0, 8'b0111_1111);
        check_all("R9 ignored selector");
        // R4 R6 R7: status kind
        send_byte(1'b1, 8'b0001_0110);
        send_byte(1'b0, 8'b0001_0110);
        check_all("R6");
        send_byte(1'b0, 8'b0011_1000);
        check_all("R6 unused ratio");
        send_byte(1'b0, 8'b0000_1100);
        check_all("R7 unused format");
        send_byte(1'b0, 8'b0100_0010);
        check_all("R6 bad prefix");
        // R4: unused kinds
        send_byte(1'b1, 8'b0001_0101);
        send_byte(1'b0, 8'b0011_1111);
        check_all("R4 kind 01");
        send_byte(1'b1, 8'b0001_0111);
        send_byte(1'b0, 8'b1000_0110);
        check_all("R4 kind 11");
        // R3: foreign address
        send_byte(1'b1, 8'b0001_1100);
        send_byte(1'b0, 8'b0000_0001);
        check_all("R3 mismatch");
        // R2: seven bits only must not write
        send_byte(1'b1, 8'b0001_0100);
        set_phase(1'b1);
        send_bits(8'b0010_1010, 7);
        wait_clk(8);
        check_all("R2 partial");
        // R11: phase change discards the partial byte
        set_phase(1'b0);
        set_phase(1'b1);
        send_byte(1'b0, 8'b0010_1010);
        check_all("R11");

        // random traffic
        for (int k = 0; k < 80; k++) begin
            logic [7:0] b;
            logic       a;
            a = ($urandom % 4) == 0;
            b = 8'($urandom);
            if (a && ($urandom % 4) != 0) b[7:2] = 6'b000101;
            if (!a && ($urandom % 2) == 0) b[6] = 1'b0;
            send_byte(a, b);
            check_all(a ? "R3 random" : "R5 random");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule